// File: doc/BRIEF.md
# Oscillator Power-Up Sequencer

This block brings a low-power clock controller from power-on reset to an awake state. It runs on a slow, always-on clock. In oscillator mode it enables the analog cells one after another. Two setup delays run back to back. The first covers supply settling and the second covers oscillator start-up. Only after both delays does the block release the system clock and gate it through to the core.

A reset-mode strap, sampled while the block sits in its reset state, selects external clock mode. In that mode an outside source guarantees a stable clock, so no delay is inserted. The first delay is zero after power-on reset, because the supplies are already stable by then. A sleep-exit request in the awake state reloads the first delay with a programmable value. This covers the core supply ramping back up before the oscillator delay runs again.

Both delays share one down-counter. A load of N keeps the sequencer in that phase for N+1 slow-clock cycles, since the phase ends when the counter is decremented from 0.

Top module: `osc_pwrup_seq`

## Requirements
- R1: While `por` is high at a rising edge, every output is 0 after that edge, whatever state the block was in.
- R2: `cell_en` is a thermometer code. It is 3'b000 in reset, 3'b001 during supply settling and 3'b011 during oscillator settling. It is 3'b111 once the clock is released. In oscillator mode, the first edge with `por` low moves the block to 3'b001.
- R3: If `ext_mode` is 1 at the first edge with `por` low, `clk_rel` is 1 after that edge, `awake` is 1 after the next one and `core_clk_en` is 1 after the one after that.
- R4: After power-on reset the supply-settling phase lasts exactly one cycle, since the counter starts from 0.
- R5: The oscillator-settling phase lasts `osc_cnt`+1 cycles. `clk_rel` rises at the edge after the phase ends.
- R6: `clk_rel` is 1 for one cycle before `awake` rises, and it stays 1 while `awake` is 1.
- R7: `core_clk_en` rises one cycle after `awake` rises, and it is 1 only while `awake` is 1.
- R8: In oscillator mode, a `sleep_exit` sampled in the awake state clears `awake`, `clk_rel` and `core_clk_en` and sets `cell_en` to 3'b001 at that edge. The supply phase then lasts `wake_cnt`+1 cycles, followed by the full oscillator phase and clock release.
- R9: `sleep_exit` has no effect outside the awake state, and it has no effect when the block was started in external clock mode.
- R10: `ext_mode` is sampled only in the reset state. Changing it later has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow always-on clock |
| por | input | 1 | Power-on reset, active high, synchronous |
| ext_mode | input | 1 | Reset-mode strap: 1 selects external clock mode |
| sleep_exit | input | 1 | Request to leave deep sleep from the awake state |
| wake_cnt | input | CNT_W | Supply-settling reload used on sleep exit |
| osc_cnt | input | CNT_W | Oscillator-settling reload |
| cell_en | output | 3 | Analog cell enables, thermometer coded |
| clk_rel | output | 1 | Internal system clock release |
| awake | output | 1 | Awake-state indication |
| core_clk_en | output | 1 | Core clock gate enable |

## Verification
The hardest situation to reach is a sleep exit. Its reload value only matters after the block has already gone through a complete power-up and reached the awake state. The bench therefore drives every power-up to the awake state first. It then pulses `sleep_exit` and sweeps both reload values over a small range, so the second pass checks every phase length against a count computed in the bench. Each power-up also injects a stray `sleep_exit` during oscillator settling and flips the strap after reset, so the ignore rules are checked as the sequence runs.

// File: rtl/osc_pwrup_seq.sv
module osc_pwrup_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             por,
  input  logic             ext_mode,
  input  logic             sleep_exit,
  input  logic [CNT_W-1:0] wake_cnt,
  input  logic [CNT_W-1:0] osc_cnt,
  output logic [2:0]       cell_en,
  output logic             clk_rel,
  output logic             awake,
  output logic             core_clk_en
);

  typedef enum logic [2:0] {S_RST, S_PSU, S_OSC, S_REL, S_AWK} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             ext_q;

  wire cnt_zero = (cnt == '0);
  wire wake_go  = (st == S_AWK) && sleep_exit && !ext_q;

  always_ff @(posedge clk) begin
    if (por) begin
      st          <= S_RST;
      cnt         <= '0;
      ext_q       <= 1'b0;
      core_clk_en <= 1'b0;
    end else begin
      core_clk_en <= (st == S_AWK) && !wake_go;
      case (st)
        S_RST: begin
          ext_q <= ext_mode;
          if (ext_mode) st <= S_REL;
          else begin
            st  <= S_PSU;
            cnt <= '0;
          end
        end
        S_PSU: begin
          if (cnt_zero) begin
            st  <= S_OSC;
            cnt <= osc_cnt;
          end else cnt <= cnt - 1'b1;
        end
        S_OSC: begin
          if (cnt_zero) st <= S_REL;
          else cnt <= cnt - 1'b1;
        end
        S_REL: st <= S_AWK;
        S_AWK: begin
          if (wake_go) begin
            st  <= S_PSU;
            cnt <= wake_cnt;
          end
        end
        default: st <= S_RST;
      endcase
    end
  end

  assign cell_en[0] = (st != S_RST);
  assign cell_en[1] = (st == S_OSC) || (st == S_REL) || (st == S_AWK);
  assign cell_en[2] = (st == S_REL) || (st == S_AWK);
  assign clk_rel    = cell_en[2];
  assign awake      = (st == S_AWK);

  a_r1_por_clears: assert property (@(posedge clk)
    por |=> (cell_en == 3'b000 && !clk_rel && !awake && !core_clk_en));

  a_r2_thermometer: assert property (@(posedge clk) disable iff (por)
    (cell_en == 3'b000 || cell_en == 3'b001 || cell_en == 3'b011 || cell_en == 3'b111));

  a_r3_ext_no_delay: assert property (@(posedge clk) disable iff (por)
    (st == S_RST && ext_mode) |=> clk_rel);

  a_r5_psu_to_osc: assert property (@(posedge clk) disable iff (por)
    (st == S_PSU && cnt_zero) |=> (st == S_OSC && cnt == $past(osc_cnt)));

  a_r5_osc_count: assert property (@(posedge clk) disable iff (por)
    (st == S_OSC && !cnt_zero) |=> (st == S_OSC && cnt == $past(cnt) - 1'b1));

  a_r5_osc_done: assert property (@(posedge clk) disable iff (por)
    (st == S_OSC && cnt_zero) |=> clk_rel && !awake);

  a_r6_release_first: assert property (@(posedge clk) disable iff (por)
    (clk_rel && !awake) |=> awake);

  a_r7_core_follows: assert property (@(posedge clk) disable iff (por)
    (awake && !core_clk_en && !sleep_exit) |=> core_clk_en);

  a_r7_core_needs_awake: assert property (@(posedge clk) disable iff (por)
    core_clk_en |-> awake);

  a_r9_wake_ignored: assert property (@(posedge clk) disable iff (por)
    (sleep_exit && st == S_OSC) |=> (st != S_PSU));

endmodule

// File: tb/tb_osc_pwrup_seq.sv
module tb_osc_pwrup_seq;
  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       ext_mode = 1'b0;
  logic       sleep_exit = 1'b0;
  logic [7:0] wake_cnt = '0;
  logic [7:0] osc_cnt = '0;
  logic [2:0] cell_en;
  logic       clk_rel, awake, core_clk_en;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;

  osc_pwrup_seq #(.CNT_W(8)) dut (
    .clk(clk), .por(por), .ext_mode(ext_mode), .sleep_exit(sleep_exit),
    .wake_cnt(wake_cnt), .osc_cnt(osc_cnt), .cell_en(cell_en),
    .clk_rel(clk_rel), .awake(awake), .core_clk_en(core_clk_en)
  );

  wire [5:0] obs = {cell_en, clk_rel, awake, core_clk_en};

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [5:0] expv(input int t, input int a, input int b, input bit ext);
    if (t <= 0) return 6'b000000;
    if (ext) begin
      if (t == 1) return 6'b111100;
      if (t == 2) return 6'b111110;
      return 6'b111111;
    end
    if (t <= a + 1)     return 6'b001000;
    if (t <= a + b + 2) return 6'b011000;
    if (t == a + b + 3) return 6'b111100;
    if (t == a + b + 4) return 6'b111110;
    return 6'b111111;
  endfunction

  function automatic string tag(input int t, input int b, input bit ext);
    if (ext)        return "R3";
    if (t == 1)     return "R2 R4";
    if (t <= b + 2) return "R5 R9 R10";
    return "R6 R7";
  endfunction

  task automatic power_up(input int b, input bit ext, input int a);
    por = 1'b1; ext_mode = ext; osc_cnt = 8'(b); wake_cnt = 8'(a); sleep_exit = 1'b0;
    tick();
    chk("R1 one-edge reset", obs, 6'b000000);
    tick();
    por = 1'b0;
    chk("R1 reset state", obs, expv(0, 0, b, ext));
    for (int t = 1; t <= b + 8; t++) begin
      tick();
      sleep_exit = 1'b0;
      chk(tag(t, b, ext), obs, expv(t, 0, b, ext));
      if (!ext && t == 1) ext_mode = 1'b1;
      if (!ext && t == 2) sleep_exit = 1'b1;
    end
    sleep_exit = 1'b1;
    if (ext) begin
      tick();
      sleep_exit = 1'b0;
      chk("R9 ext wake ignored", obs, 6'b111111);
      tick();
      chk("R9 ext wake ignored", obs, 6'b111111);
    end else begin
      for (int t = 1; t <= a + b + 7; t++) begin
        tick();
        sleep_exit = 1'b0;
        chk("R8 sleep exit", obs, expv(t, a, b, 1'b0));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < 7; b++) begin
      for (int a = 0; a < 7; a++) power_up(b, 1'b0, a);
      power_up(b, 1'b1, 0);
    end
    por = 1'b1; ext_mode = 1'b0; osc_cnt = 8'd5;
    tick();
    tick();
    por = 1'b0;
    tick(); tick(); tick();
    chk("R5 mid sequence", obs, 6'b011000);
    por = 1'b1;
    tick();
    chk("R1 mid sequence reset", obs, 6'b000000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule